// File: doc/BRIEF.md
# Synchronous Burst SRAM Front End

This block is the clocked control front end of a burst-capable static memory with a 32-bit word split into four byte lanes. On each rising clock edge it samples a word address, three chip-select inputs, two address-load strobes, a burst-step input and a set of write controls. From these it decides whether the cycle opens a new burst, continues the current one, or shuts the device off. It then forms the per-lane write enables for an internal register-file array.

There are two load strobes with different rules. The host-side strobe has priority and can never write in its own cycle. The controller-side strobe works even when the device is deselected, and it can restart a write burst at a new address in the middle of a burst. Inside a burst, the step input either moves a two-bit counter through four consecutive words or holds the address so the same word is accessed again. A read returns its word in the cycle after the access. The output-enable input only decides whether that word is driven.

Top module: `burst_sram_ctl`

## Requirements
- R1: The device is selected only when `sel_a_n`=0, `sel_b_n`=0 and `sel_c`=1. A load-strobe cycle under any other combination performs no read and no write.
- R2: With `all_wr_n`=0, an access writes all four lanes, whatever `lane_gate_n` and `lane_wr_n` are.
- R3: With `all_wr_n`=1 and `lane_gate_n`=0, only the lanes whose `lane_wr_n` bit is 0 are written. Lane i is `wdata[8i+7:8i]`.
- R4: With `all_wr_n`=1 and `lane_gate_n`=1, an access is a read and leaves the array unchanged.
- R5: A cycle in which the host strobe `cpu_ld_n`=0 is taken (with `sel_a_n`=0) loads `addr` and is a read, even when the write controls request a write.
- R6: In a burst cycle with no strobe taken and `step_n`=1, the access uses the same address as the previous access. This is how a write reaches a freshly loaded address.
- R7: In a burst cycle with no strobe taken and `step_n`=0, the access uses the next address. The low two address bits count up and wrap from 3 to 0. The upper bits never change.
- R8: When both strobes are low with `sel_a_n`=0, the host strobe wins. Otherwise a low `ctl_ld_n` on a selected device loads `addr`, restarts the burst there, and may write in that same cycle.
- R9: A low `cpu_ld_n` is ignored while `sel_a_n`=1. A taken `ctl_ld_n` on a deselected device ends the burst, so later cycles without a strobe access nothing.
- R10: Read data for an access is presented in the following cycle. `dq_oe` is 1 only if that cycle's `out_en_n` is 0. A write, or a cycle with no access, leaves `dq_oe` at 0 in the next cycle.
- R11: After reset no burst is active and `dq_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| sel_a_n | input | 1 | Select, active low; also gates the host strobe |
| sel_b_n | input | 1 | Select, active low |
| sel_c | input | 1 | Select, active high |
| cpu_ld_n | input | 1 | Host-side address-load strobe, active low |
| ctl_ld_n | input | 1 | Controller-side address-load strobe, active low |
| step_n | input | 1 | Burst step, active low; high holds the address |
| all_wr_n | input | 1 | Global full-word write, active low |
| lane_gate_n | input | 1 | Enables per-lane writes, active low |
| lane_wr_n | input | 4 | Per-lane write enables, active low |
| out_en_n | input | 1 | Output enable for read data, active low |
| addr | input | 6 | Word address |
| wdata | input | 32 | Write data |
| dq_out | output | 32 | Read data |
| dq_oe | output | 1 | Read data is driven |

## Verification
The hardest state to reach is a live write burst that is interrupted: either by a controller-strobe reload at a fresh address, or by a controller strobe on a deselected device followed by write attempts that must land nowhere. Random stimulus rarely lines these up. So a directed phase first fills every word with a known pattern, then steps a write burst across the wrap point, reloads it midway, kills it with a deselected strobe, and reads each affected word back through host-strobe loads. A long seeded random phase follows, checked against a bench model of the burst state and the array.

// File: rtl/sbs_pkg.sv
package sbs_pkg;

    typedef enum logic [1:0] {
        ST_NONE     = 2'd0,
        ST_LOAD_CPU = 2'd1,
        ST_LOAD_CTL = 2'd2,
        ST_DESEL    = 2'd3
    } strobe_e;

    function automatic logic [1:0] wrap_inc(input logic [1:0] v);
        return v + 2'd1;
    endfunction

endpackage

// File: rtl/sbs_decode.sv
module sbs_decode
    import sbs_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic             sel_a_n,
    input  logic             sel_b_n,
    input  logic             sel_c,
    input  logic             cpu_ld_n,
    input  logic             ctl_ld_n,
    input  logic             step_n,
    input  logic             all_wr_n,
    input  logic             lane_gate_n,
    input  logic [LANES-1:0] lane_wr_n,
    output strobe_e          st,
    output logic             advance,
    output logic [LANES-1:0] wr_mask
);
    logic chip_on;
    logic cpu_hit;
    logic ctl_hit;
    logic [LANES-1:0] raw_mask;

    always_comb begin
        chip_on = !sel_a_n && !sel_b_n && sel_c;
        cpu_hit = !cpu_ld_n && !sel_a_n;
        ctl_hit = !ctl_ld_n && !cpu_hit;

        if (cpu_hit)      st = chip_on ? ST_LOAD_CPU : ST_DESEL;
        else if (ctl_hit) st = chip_on ? ST_LOAD_CTL : ST_DESEL;
        else              st = ST_NONE;

        if (!all_wr_n)         raw_mask = '1;
        else if (!lane_gate_n) raw_mask = ~lane_wr_n;
        else                   raw_mask = '0;

        wr_mask = (st == ST_LOAD_CPU) ? '0 : raw_mask;
        advance = !step_n;
    end

endmodule

// File: rtl/sbs_burst.sv
module sbs_burst
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  strobe_e           st,
    input  logic              advance,
    input  logic [ADDR_W-1:0] addr_in,
    output logic [ADDR_W-1:0] acc_addr,
    output logic              access
);
    logic              active_q;
    logic [ADDR_W-1:0] burst_q;
    logic              cont;

    always_comb begin
        cont = (st == ST_NONE) && active_q;
        access = (st == ST_LOAD_CPU) || (st == ST_LOAD_CTL) || cont;
        if (st == ST_LOAD_CPU || st == ST_LOAD_CTL)
            acc_addr = addr_in;
        else if (cont && advance)
            acc_addr = {burst_q[ADDR_W-1:2], wrap_inc(burst_q[1:0])};
        else
            acc_addr = burst_q;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            active_q <= 1'b0;
            burst_q  <= '0;
        end else begin
            if (st == ST_DESEL)
                active_q <= 1'b0;
            else if (st != ST_NONE)
                active_q <= 1'b1;
            if (access)
                burst_q <= acc_addr;
        end
    end

    // R7
    step_wrap_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_NONE && active_q && advance) |=>
            (burst_q[1:0] == $past(burst_q[1:0]) + 2'd1) &&
            (burst_q[ADDR_W-1:2] == $past(burst_q[ADDR_W-1:2])));

    // R6
    hold_addr_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_NONE && active_q && !advance) |=> $stable(burst_q));

    // R9
    desel_end_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_DESEL) |=> !active_q);

    // R8
    reload_chk: assert property (@(posedge clk) disable iff (rst)
        (st == ST_LOAD_CPU || st == ST_LOAD_CTL) |=>
            active_q && (burst_q == $past(addr_in)));

endmodule

// File: rtl/sbs_array.sv
module sbs_array #(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    access,
    input  logic [ADDR_W-1:0]       acc_addr,
    input  logic [LANES-1:0]        wr_mask,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] rd_data,
    output logic                    rd_valid
);
    localparam int DEPTH = 1 << ADDR_W;

    logic rd_en;
    assign rd_en = access && (wr_mask == '0);

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] mem [DEPTH];
        logic [LANE_W-1:0] rd_byte;

        always_ff @(posedge clk) begin
            if (access && wr_mask[g])
                mem[acc_addr] <= wdata[g*LANE_W +: LANE_W];
            if (rd_en)
                rd_byte <= mem[acc_addr];
        end

        assign rd_data[g*LANE_W +: LANE_W] = rd_byte;
    end

    always_ff @(posedge clk) begin
        if (rst) rd_valid <= 1'b0;
        else     rd_valid <= rd_en;
    end

    // R10
    wr_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
        (access && (wr_mask != '0)) |=> !rd_valid);

    // R10
    idle_no_rd_chk: assert property (@(posedge clk) disable iff (rst)
        !access |=> !rd_valid);

endmodule

// File: rtl/burst_sram_ctl.sv
module burst_sram_ctl
    import sbs_pkg::*;
#(
    parameter int ADDR_W = 6,
    parameter int LANES  = 4,
    parameter int LANE_W = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    sel_a_n,
    input  logic                    sel_b_n,
    input  logic                    sel_c,
    input  logic                    cpu_ld_n,
    input  logic                    ctl_ld_n,
    input  logic                    step_n,
    input  logic                    all_wr_n,
    input  logic                    lane_gate_n,
    input  logic [LANES-1:0]        lane_wr_n,
    input  logic                    out_en_n,
    input  logic [ADDR_W-1:0]       addr,
    input  logic [LANES*LANE_W-1:0] wdata,
    output logic [LANES*LANE_W-1:0] dq_out,
    output logic                    dq_oe
);
    strobe_e           st;
    logic              advance;
    logic [LANES-1:0]  wr_mask;
    logic [ADDR_W-1:0] acc_addr;
    logic              access;
    logic              rd_valid;

    sbs_decode #(.LANES(LANES)) u_decode (
        .sel_a_n     (sel_a_n),
        .sel_b_n     (sel_b_n),
        .sel_c       (sel_c),
        .cpu_ld_n    (cpu_ld_n),
        .ctl_ld_n    (ctl_ld_n),
        .step_n      (step_n),
        .all_wr_n    (all_wr_n),
        .lane_gate_n (lane_gate_n),
        .lane_wr_n   (lane_wr_n),
        .st          (st),
        .advance     (advance),
        .wr_mask     (wr_mask)
    );

    sbs_burst #(.ADDR_W(ADDR_W)) u_burst (
        .clk      (clk),
        .rst      (rst),
        .st       (st),
        .advance  (advance),
        .addr_in  (addr),
        .acc_addr (acc_addr),
        .access   (access)
    );

    sbs_array #(.ADDR_W(ADDR_W), .LANES(LANES), .LANE_W(LANE_W)) u_array (
        .clk      (clk),
        .rst      (rst),
        .access   (access),
        .acc_addr (acc_addr),
        .wr_mask  (wr_mask),
        .wdata    (wdata),
        .rd_data  (dq_out),
        .rd_valid (rd_valid)
    );

    assign dq_oe = rd_valid && !out_en_n;

    // R11
    rst_quiet_chk: assert property (@(posedge clk) rst |=> !dq_oe);

    // R5
    cpu_load_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!cpu_ld_n && !sel_a_n && !sel_b_n && sel_c) |=> rd_valid);

endmodule

// File: tb/burst_sram_ctl_bench.sv
`timescale 1ns/1ps
module burst_sram_ctl_bench;
    localparam int AW = 6;
    localparam int DEPTH = 1 << AW;

    logic        clk = 1'b0;
    logic        rst;
    logic        sel_a_n, sel_b_n, sel_c;
    logic        cpu_ld_n, ctl_ld_n, step_n;
    logic        all_wr_n, lane_gate_n;
    logic [3:0]  lane_wr_n;
    logic        out_en_n;
    logic [AW-1:0] addr;
    logic [31:0] wdata;
    logic [31:0] dq_out;
    logic        dq_oe;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [31:0]   mdl [DEPTH];
    logic          m_act;
    logic [AW-1:0] m_addr;
    logic          exp_valid;
    logic [31:0]   exp_data;

    always #2 clk = ~clk;

    burst_sram_ctl #(.ADDR_W(AW)) u_burst_sram_ctl (
        .clk(clk), .rst(rst), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n), .sel_c(sel_c),
        .cpu_ld_n(cpu_ld_n), .ctl_ld_n(ctl_ld_n), .step_n(step_n),
        .all_wr_n(all_wr_n), .lane_gate_n(lane_gate_n), .lane_wr_n(lane_wr_n),
        .out_en_n(out_en_n), .addr(addr), .wdata(wdata),
        .dq_out(dq_out), .dq_oe(dq_oe)
    );

    function automatic logic [3:0] lane_mask(input logic gw_n, input logic gate_n,
                                             input logic [3:0] ln_n);
        if (!gw_n)   return 4'hF;
        if (!gate_n) return ~ln_n;
        return 4'h0;
    endfunction

    function automatic logic [AW-1:0] next_addr(input logic [AW-1:0] a);
        return {a[AW-1:2], a[1:0] + 2'd1};
    endfunction

    task automatic model_step();
        logic sel, cpu_hit, ctl_hit, load, desel, cont, acc;
        logic [AW-1:0] a;
        logic [3:0] m;
        sel     = !sel_a_n && !sel_b_n && sel_c;
        cpu_hit = !cpu_ld_n && !sel_a_n;
        ctl_hit = !ctl_ld_n && !cpu_hit;
        load    = (cpu_hit || ctl_hit) && sel;
        desel   = (cpu_hit || ctl_hit) && !sel;
        cont    = !cpu_hit && !ctl_hit && m_act;
        acc     = load || cont;
        a = load ? addr : ((!step_n && cont) ? next_addr(m_addr) : m_addr);
        m = cpu_hit ? 4'h0 : lane_mask(all_wr_n, lane_gate_n, lane_wr_n);
        exp_valid = acc && (m == 4'h0);
        if (exp_valid) exp_data = mdl[a];
        if (acc) begin
            for (int i = 0; i < 4; i++)
                if (m[i]) mdl[a][i*8 +: 8] = wdata[i*8 +: 8];
            m_addr = a;
        end
        if (load) m_act = 1'b1;
        else if (desel) m_act = 1'b0;
    endtask

    task automatic check_out(input string tag);
        logic eoe;
        eoe = exp_valid && !out_en_n;
        total++;
        if (dq_oe !== eoe) begin
            bad++;
            $display("FAIL %s: dq_oe actual=%0b expected=%0b", tag, dq_oe, eoe);
        end else if (eoe) begin
            total++;
            if (dq_out !== exp_data) begin
                bad++;
                $display("FAIL %s: dq_out actual=%08h expected=%08h", tag, dq_out, exp_data);
            end
        end
    endtask

    task automatic tick(input string tag);
        model_step();
        @(posedge clk);
        @(negedge clk);
        check_out(tag);
    endtask

    task automatic idle_in();
        sel_a_n = 0; sel_b_n = 0; sel_c = 1;
        cpu_ld_n = 1; ctl_ld_n = 1; step_n = 1;
        all_wr_n = 1; lane_gate_n = 1; lane_wr_n = 4'hF;
        out_en_n = 0; addr = '0; wdata = '0;
    endtask

    task automatic host_read(input logic [AW-1:0] a, input string tag);
        idle_in(); cpu_ld_n = 0; addr = a;
        tick(tag);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            bad++; total++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        idle_in();
        rst = 1;
        m_act = 0; m_addr = '0; exp_valid = 0; exp_data = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R11: output quiet during reset
        total++;
        if (dq_oe !== 1'b0) begin bad++; $display("FAIL R11: dq_oe actual=%0b expected=0", dq_oe); end
        rst = 0;
        tick("R11");

        // R2: fill all words with controller-strobe full writes, lane enables high
        for (int i = 0; i < DEPTH; i++) begin
            idle_in(); ctl_ld_n = 0; addr = AW'(i); all_wr_n = 0;
            wdata = 32'hA5000000 | (i * 32'h00010101);
            tick("R2");
        end
        host_read(6'd8, "R2");

        // R6: write to loaded address with step held
        host_read(6'd8, "R6");
        idle_in(); all_wr_n = 0; wdata = 32'h11112222; tick("R6");
        idle_in(); tick("R6");
        // R7: step through 9,10,11 and wrap to 8, writing
        for (int i = 0; i < 4; i++) begin
            idle_in(); step_n = 0; all_wr_n = 0; wdata = 32'h70000000 + i;
            tick("R7");
        end
        for (int i = 8; i < 12; i++) host_read(AW'(i), "R7");
        host_read(6'd12, "R7");

        // R3: per-lane write at 9, lanes 0 and 2
        idle_in(); ctl_ld_n = 0; addr = 6'd9; lane_gate_n = 0; lane_wr_n = 4'b1010;
        wdata = 32'hFFFFFFFF; tick("R3");
        host_read(6'd9, "R3");
        // R4: gate high with lane enables low is a read
        idle_in(); lane_wr_n = 4'h0; wdata = 32'h0; tick("R4");
        host_read(6'd9, "R4");

        // R5: host strobe with write request is a read
        idle_in(); cpu_ld_n = 0; addr = 6'd10; all_wr_n = 0; wdata = 32'hDEADBEEF; tick("R5");
        idle_in(); tick("R5");

        // R8: controller reload mid write burst
        idle_in(); ctl_ld_n = 0; addr = 6'd16; all_wr_n = 0; wdata = 32'h0BAD0016; tick("R8");
        idle_in(); step_n = 0; all_wr_n = 0; wdata = 32'h0BAD0017; tick("R8");
        idle_in(); ctl_ld_n = 0; addr = 6'd30; all_wr_n = 0; wdata = 32'h0BAD0030; tick("R8");
        idle_in(); step_n = 0; all_wr_n = 0; wdata = 32'h0BAD0031; tick("R8");
        host_read(6'd16, "R8"); host_read(6'd17, "R8");
        host_read(6'd30, "R8"); host_read(6'd31, "R8");
        // R8: both strobes low, host strobe wins (no write)
        idle_in(); cpu_ld_n = 0; ctl_ld_n = 0; addr = 6'd40; all_wr_n = 0;
        wdata = 32'h12345678; tick("R8");
        host_read(6'd40, "R8");

        // R9: host strobe ignored while sel_a_n high
        host_read(6'd20, "R9");
        idle_in(); sel_a_n = 1; cpu_ld_n = 0; addr = 6'd50; step_n = 0; tick("R9");
        host_read(6'd50, "R9"); host_read(6'd21, "R9");
        // R9: deselected controller strobe ends the burst
        host_read(6'd22, "R9");
        idle_in(); sel_b_n = 1; ctl_ld_n = 0; addr = 6'd44; all_wr_n = 0; tick("R9");
        idle_in(); all_wr_n = 0; wdata = 32'hCAFE0000; tick("R9");
        idle_in(); step_n = 0; all_wr_n = 0; wdata = 32'hCAFE0001; tick("R9");
        host_read(6'd22, "R9"); host_read(6'd23, "R9"); host_read(6'd44, "R9");

        // R1: selects wrong on controller strobe write
        idle_in(); sel_c = 0; ctl_ld_n = 0; addr = 6'd33; all_wr_n = 0; wdata = 32'h0; tick("R1");
        idle_in(); sel_a_n = 1; ctl_ld_n = 0; addr = 6'd34; all_wr_n = 0; wdata = 32'h0; tick("R1");
        host_read(6'd33, "R1"); host_read(6'd34, "R1");

        // R10: output enable high hides read data, then low shows next one
        idle_in(); cpu_ld_n = 0; addr = 6'd5; out_en_n = 1; tick("R10");
        idle_in(); step_n = 0; tick("R10");

        // Random phase
        for (int n = 0; n < 3000; n++) begin
            int r;
            r = $urandom % 16;
            sel_a_n = (r == 0); sel_b_n = (r == 1); sel_c = (r != 2);
            cpu_ld_n = ($urandom % 6) != 0;
            ctl_ld_n = ($urandom % 6) != 0;
            step_n = $urandom % 2;
            all_wr_n = ($urandom % 4) != 0;
            lane_gate_n = $urandom % 2;
            lane_wr_n = 4'($urandom);
            out_en_n = ($urandom % 5) == 0;
            addr = AW'($urandom);
            wdata = $urandom;
            tick("R10");
        end

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule